// File: doc/BRIEF.md
# Registered 8-Bit Arithmetic Logic Unit

This block is a one-stage synchronous arithmetic logic unit. On every rising clock edge it captures two operands and a 4-bit function code into input registers. On the next rising edge it captures the 8-bit result, a carry flag and a zero flag into output registers. Any operation therefore reaches the outputs one clock after its operands were captured. A new operation can be issued every cycle.

Every arithmetic code uses the same adder. That adder builds its carries from generate and propagate terms through a lookahead network, not a ripple chain. The function code does not pick a separate datapath for each operation. Instead it masks the adder inputs and sets the carry-in, which covers addition, addition plus one, addition of the complemented second operand, increment, and moving either operand through unchanged. Four bitwise functions are computed next to the adder. The result multiplexer picks between the adder output and the bitwise output.

Top module: `alu8_reg`

## Requirements
- R1: While `rst_ni` is low, `result_o`, `carry_o` and `zero_o` are all 0. The reset is asynchronous, so these outputs clear without waiting for a clock edge.
- R2: Operands and code are sampled at a rising edge. The matching result and flags appear after the next rising edge. One operation can be issued per cycle.
- R3: Code 0 gives `result_o` = (A+B) mod 256, with `carry_o` set to bit 8 of the 9-bit sum.
- R4: Code 1 gives (A+B+1) mod 256, with `carry_o` set to bit 8 of A+B+1.
- R5: Code 2 gives (A+~B) mod 256 with carry-in 0, and `carry_o` is bit 8 of that sum.
- R6: Code 3 returns A and code 4 returns B. For both codes `carry_o` is 0.
- R7: Code 5 gives (A+1) mod 256, with `carry_o` set when A is 255.
- R8: The bitwise codes are 6 XOR, 7 AND, 8 OR and 9 NOT A (NOT A ignores B). For these codes `carry_o` is 0.
- R9: Codes 10 to 15 give `result_o` = 0 and `carry_o` = 0.
- R10: After an operation, `zero_o` is 1 exactly when the registered `result_o` is all zeros.
- R11: The adder's 9-bit output equals the arithmetic sum of its two gated operands and its carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| op_i | input | 4 | Function code |
| result_o | output | 8 | Registered result |
| carry_o | output | 1 | Registered carry-out flag |
| zero_o | output | 1 | Registered zero flag |

## Verification
Operands driven before rising edge N are captured at N. Their result, carry and zero flag are captured at edge N+1 and are read at the falling edge that follows, two cycle counts after the driver ran. Each time the driver issues an operation, it pushes the expected triple into a queue tagged with that due count. A monitor samples at every falling edge and compares the head entry only when its due count matches. A result that arrives one cycle early or late is compared against the wrong operation and is reported. Reset is checked a few picoseconds after `rst_ni` falls, with no clock edge in between.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 4'd0,
    OP_ADD1   = 4'd1,
    OP_ADDNB  = 4'd2,
    OP_PASS_A = 4'd3,
    OP_PASS_B = 4'd4,
    OP_INC_A  = 4'd5,
    OP_XOR    = 4'd6,
    OP_AND    = 4'd7,
    OP_OR     = 4'd8,
    OP_NOT_A  = 4'd9
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = OP_NOT_A;
endpackage

// File: rtl/alu_cla_adder.sv
module alu_cla_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] gen, prop;
  logic [W:0]   carry;

  assign gen  = a_i & b_i;
  assign prop = a_i ^ b_i;

  // every carry is a flat sum of products over g/p, no chained carry term
  function automatic logic [W:0] lookahead(input logic [W-1:0] g,
                                           input logic [W-1:0] p,
                                           input logic         ci);
    logic [W:0] c;
    logic       term;
    c = '0;
    c[0] = ci;
    for (int i = 1; i <= W; i++) begin
      term = ci;
      for (int k = 0; k < i; k++) term = term & p[k];
      c[i] = term;
      for (int j = 0; j < i; j++) begin
        term = g[j];
        for (int k = j + 1; k < i; k++) term = term & p[k];
        c[i] = c[i] | term;
      end
    end
    return c;
  endfunction

  assign carry  = lookahead(gen, prop, cin_i);
  assign sum_o  = prop ^ carry[W-1:0];
  assign cout_o = carry[W];

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      // R11
      adder_sum_chk: assert ({cout_o, sum_o} ==
                             ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
        else $error("lookahead sum mismatch");
    end
  end
endmodule

// File: rtl/alu_operand_gate.sv
module alu_operand_gate
  import alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    add_a_o,
  output logic [W-1:0]    add_b_o,
  output logic            cin_o,
  output logic            arith_o
);
  always_comb begin
    add_a_o = a_i;
    add_b_o = b_i;
    cin_o   = 1'b0;
    arith_o = 1'b1;
    case (op_i)
      OP_ADD:    ;
      OP_ADD1:   cin_o = 1'b1;
      OP_ADDNB:  add_b_o = ~b_i;
      OP_PASS_A: add_b_o = '0;
      OP_PASS_B: add_a_o = '0;
      OP_INC_A: begin
        add_b_o = '0;
        cin_o   = 1'b1;
      end
      default: begin
        add_a_o = '0;
        add_b_o = '0;
        arith_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    res_o,
  output logic            logic_o
);
  always_comb begin
    res_o   = '0;
    logic_o = 1'b1;
    case (op_i)
      OP_XOR:   res_o = a_i ^ b_i;
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_NOT_A: res_o = ~a_i;
      default:  logic_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu8_reg.sv
module alu8_reg
  import alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    result_o,
  output logic            carry_o,
  output logic            zero_o
);
  logic [W-1:0]    a_q, b_q;
  logic [OP_W-1:0] op_q;
  logic [W-1:0]    add_a, add_b, sum, logic_res, res_d;
  logic            cin, cout, arith_en, logic_en, carry_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      b_q  <= '0;
      op_q <= '0;
    end else begin
      a_q  <= a_i;
      b_q  <= b_i;
      op_q <= op_i;
    end
  end

  alu_operand_gate #(.W(W)) u_gate (
    .a_i(a_q), .b_i(b_q), .op_i(op_q),
    .add_a_o(add_a), .add_b_o(add_b), .cin_o(cin), .arith_o(arith_en)
  );

  alu_cla_adder #(.W(W)) u_adder (
    .a_i(add_a), .b_i(add_b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .a_i(a_q), .b_i(b_q), .op_i(op_q), .res_o(logic_res), .logic_o(logic_en)
  );

  always_comb begin
    res_d   = '0;
    carry_d = 1'b0;
    if (arith_en) begin
      res_d   = sum;
      carry_d = cout;
    end else if (logic_en) begin
      res_d = logic_res;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
    end else begin
      result_o <= res_d;
      carry_o  <= carry_d;
      zero_o   <= (res_d == '0);
    end
  end

  // R8
  one_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arith_en && logic_en));

  // R6
  pass_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_PASS_A) |=> (result_o == $past(a_q) && !carry_o));

  // R8
  logic_no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q >= OP_XOR && op_q <= OP_LAST) |=> !carry_o);

  // R9
  unused_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q > OP_LAST) |=> (result_o == '0 && !carry_o));

  // R10
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (result_o == '0));

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_PASS_B) |=> (result_o == $past(b_q)));
endmodule

// File: tb/tb_alu8_reg.sv
`timescale 1ns/1ps
module tb_alu8_reg;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [3:0] op = '0;
  logic [7:0] result;
  logic       carry, zero;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int         due;
    logic [7:0] res;
    logic       cy;
    logic       z;
    logic [3:0] op;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  alu8_reg dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .op_i(op),
    .result_o(result), .carry_o(carry), .zero_o(zero)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3, 4'd4: return "R6";
      4'd5: return "R7";
      4'd6, 4'd7, 4'd8, 4'd9: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic exp_t model(input logic [7:0] x, input logic [7:0] y,
                                 input logic [3:0] o);
    exp_t e;
    logic [8:0] s;
    s = 9'd0;
    case (o)
      4'd0: s = {1'b0, x} + {1'b0, y};
      4'd1: s = {1'b0, x} + {1'b0, y} + 9'd1;
      4'd2: s = {1'b0, x} + {1'b0, ~y};
      4'd3: s = {1'b0, x};
      4'd4: s = {1'b0, y};
      4'd5: s = {1'b0, x} + 9'd1;
      4'd6: s = {1'b0, x ^ y};
      4'd7: s = {1'b0, x & y};
      4'd8: s = {1'b0, x | y};
      4'd9: s = {1'b0, ~x};
      default: s = 9'd0;
    endcase
    e.res = s[7:0];
    e.cy  = s[8];
    e.z   = (s[7:0] == 8'd0);
    e.op  = o;
    e.due = 0;
    return e;
  endfunction

  task automatic drive(input logic [7:0] x, input logic [7:0] y,
                       input logic [3:0] o);
    exp_t e;
    @(negedge clk);
    a  = x;
    b  = y;
    op = o;
    e = model(x, y, o);
    e.due = cyc + 2; // R2: input edge then result edge
    sb.push_back(e);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && sb.size() != 0) begin
      if (sb[0].due < cyc) begin
        errors++;
        $display("FAIL R2 missed slot: actual cyc %0d expected cyc %0d", cyc, sb[0].due);
        void'(sb.pop_front());
      end else if (sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (result !== e.res || carry !== e.cy) begin
          errors++;
          $display("FAIL %s op %0d: actual res %02h cy %b expected res %02h cy %b",
                   req_of(e.op), e.op, result, carry, e.res, e.cy);
        end
        checks++;
        if (zero !== e.z) begin
          errors++;
          $display("FAIL R10 op %0d: actual zero %b expected %b", e.op, zero, e.z);
        end
      end
    end
  end

  task automatic check_reset();
    checks++;
    if (result !== 8'd0 || carry !== 1'b0 || zero !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual res %02h cy %b z %b expected 00 0 0", result, carry, zero);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    logic [7:0] pa [6];
    logic [7:0] pb [6];
    pa = '{8'h00, 8'hFF, 8'hFF, 8'h5A, 8'h05, 8'h80};
    pb = '{8'h00, 8'h01, 8'hFF, 8'hA5, 8'h03, 8'h80};

    #1 check_reset(); // R1 before any clock edge
    repeat (3) @(negedge clk);
    check_reset();
    rst_ni = 1'b1;

    // R3..R10 on corner operand pairs for every code
    for (int o = 0; o < 16; o++)
      for (int k = 0; k < 6; k++)
        drive(pa[k], pb[k], 4'(o));
    drain();

    // R4/R5/R7 carry corners, R10 zero after wrap
    drive(8'hFF, 8'h00, 4'd1); // 0x100: res 0 carry 1 zero 1
    drive(8'h37, 8'h37, 4'd2); // a+~a = 0xFF, no carry
    drive(8'hFF, 8'h12, 4'd5); // 255+1 wraps
    drive(8'hFF, 8'hFF, 4'd9); // NOT A -> 0
    drive(8'h00, 8'hC3, 4'd4); // pass B
    drain();

    // back-to-back random stream
    lfsr = 8'hA1;
    for (int n = 0; n < 300; n++) begin
      logic [7:0] ra, rb;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ra = lfsr;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rb = lfsr;
      drive(ra, rb, 4'(n % 16));
    end
    drain();

    // R1: asynchronous clear mid-run
    drive(8'h80, 8'h80, 4'd0); // res 00 carry 1
    drive(8'h12, 8'h34, 4'd8); // res 36, nonzero state before reset
    drain();
    #0.5 rst_ni = 1'b0;
    #0.2 check_reset();
    @(negedge clk);
    check_reset();
    rst_ni = 1'b1;
    drive(8'h01, 8'h02, 4'd0);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule